// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block sequences bus cycles to the external address space of a microcontroller. A requester presents one access: a byte address, a read or write flag, a size flag for 8 or 16 bits, write data, and a region code. The region code selects the basic expansion area, the CP expansion area or the CF expansion area. The block then runs the access states on the external bus, drives the address, the address, read and write strobes and the data-bus direction, and returns a one-cycle completion pulse. For reads, the assembled data comes back in the same cycle as that pulse.

Two groups of configuration inputs set the timing. One group serves the basic area. The other is shared by the CP and CF areas. Each group picks a bus width of 8 or 16 bits, picks 2-state or 3-state access, and carries a program wait code. On an 8-bit bus a 16-bit access becomes two byte cycles, and each byte cycle gets its full state sequence. The CP/CF wait code does not map linearly to a wait count. Only the CF area may use the upper half of its range. The block reports an illegal code on a CP access through an error output.

Top module: `ext_wait_ctrl`

## Requirements
- R1: A request is taken only in a cycle where the bus is idle (`bus_as_n` high) and `req_valid` is high, and the first access state follows in the next cycle. A `req_valid` pulse while an access is running is ignored: it does not change that access and it does not start a later one.
- R2: When the region's 3-state bit is 0, each byte cycle lasts exactly 2 clocks and no wait state is inserted, whatever the wait code holds.
- R3: When the region's 3-state bit is 1, each byte cycle lasts 3 clocks plus the number of wait states, and the waits sit between the second and the last state.
- R4: For the CF region (`req_region` = 2), CP/CF wait codes 0, 1, 2 and 3 insert 0, 1, 2 and 3 waits, and codes 4, 5, 6 and 7 insert 4, 6, 8 and 10 waits. The basic region (`req_region` = 0 or 3) inserts as many waits as its 2-bit code holds.
- R5: CP and CF accesses get waits only when `cfg_cpcf_en` and `cfg_cpcf_3st` are both 1. With `cfg_cpcf_en` at 0 and `cfg_cpcf_3st` at 1, the access has 3 states and no waits.
- R6: A CP access (`req_region` = 1) whose wait count applies and whose code has bit 2 set is illegal. `cfg_err` is then high in every cycle of that access and low at all other times, and the waits follow code bits 1:0.
- R7: A `cfg_*_wide` value of 1 selects a 16-bit bus and 0 selects an 8-bit bus. When `cfg_card_mode` is 1, CP accesses use a 16-bit bus whatever `cfg_cpcf_wide` holds. CF accesses are not affected.
- R8: A 16-bit access (`req_size16` = 1) on an 8-bit bus runs two byte cycles. The first goes to the even address and carries the upper byte. The second goes to the odd address and carries the lower byte. Read data returns as {first byte, second byte}.
- R9: A 16-bit bus carries a word at the even address on `bus_wdata[15:8]` and `bus_wdata[7:0]`, a byte at an even address on [15:8] and a byte at an odd address on [7:0]. An 8-bit bus uses lane [7:0] only, with the upper lane at zero. A byte read returns in `req_rdata[7:0]` with the upper byte at zero.
- R10: During an access, `bus_as_n` is low in every state. For a read, `bus_rd_n` is low in every state. For a write, `bus_wr_n` is low in every state except the first of each byte cycle, and `bus_data_oe` is high throughout. When idle, the strobes are high, `bus_data_oe` is 0, and `bus_addr` and `bus_wdata` are zero.
- R11: `req_ready` is high for exactly one cycle, in the final state of the final byte cycle. In that cycle of a read, `req_rdata` holds the read data. At all other times `req_rdata` is zero.
- R12: The region configuration is captured when a request is taken. Changing it while an access runs does not alter that access.
- R13: After synchronous reset the bus is idle, with the output values that R10 gives for idle, and `req_ready` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, taken while idle |
| req_addr | input | AW | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size16 | input | 1 | 1 = 16-bit access, 0 = byte access |
| req_region | input | 2 | 0 basic, 1 CP, 2 CF, 3 handled as basic |
| req_wdata | input | 16 | Write data (byte accesses use [7:0]) |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid while req_ready is high |
| cfg_basic_wide | input | 1 | Basic area bus width, 1 = 16 bits |
| cfg_basic_3st | input | 1 | Basic area 3-state access |
| cfg_basic_code | input | BASIC_CODE_W | Basic area wait count |
| cfg_cpcf_en | input | 1 | CP/CF wait count enable |
| cfg_cpcf_wide | input | 1 | CP/CF bus width, 1 = 16 bits |
| cfg_cpcf_3st | input | 1 | CP/CF 3-state access |
| cfg_cpcf_code | input | 3 | CP/CF wait code |
| cfg_card_mode | input | 1 | Memory card mode, forces 16-bit CP bus |
| cfg_err | output | 1 | Illegal CP wait code in the running access |
| bus_addr | output | AW | External address |
| bus_as_n | output | 1 | Address strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_data_oe | output | 1 | Data bus driven by this block |
| bus_wdata | output | 16 | Write data onto the bus lanes |
| bus_rdata | input | 16 | Read data from the bus lanes |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a 2-bit basic wait code. Under these settings the full 3-bit CP/CF code range can be exercised, up to the 10-wait maximum, along with every basic count from 0 to 3. The wide address lets the bench's external memory model derive both data lanes from the address, so a swapped byte, a wrong lane or a wrong even/odd address in a split access shows up as a data mismatch. The model predicts every bus and requester output for each cycle from the configuration present when the request was issued. This prediction exposes extra or missing wait states, late or repeated completion pulses, and any effect of a configuration change or a stray request during an access.

// File: rtl/ewc_pkg.sv
`timescale 1ns/1ps
// Shared types and constants for the external bus wait-state controller.
// Assumes a data path of two byte lanes and a 3-bit CP/CF wait code.
package ewc_pkg;
    localparam int LANE_W    = 8;
    localparam int BUS_W     = 2 * LANE_W;
    localparam int CODE_W    = 3;
    localparam int MAX_WAITS = 10;
    localparam int CNT_W     = $clog2(MAX_WAITS + 1);

    typedef enum logic [1:0] {
        RGN_BASIC = 2'd0,
        RGN_CP    = 2'd1,
        RGN_CF    = 2'd2,
        RGN_RSVD  = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_TW   = 3'd3,
        ST_T3   = 3'd4
    } bus_st_e;

    // Timing plan for one access, captured when a request is taken.
    typedef struct packed {
        logic             wide;
        logic             three;
        logic [CNT_W-1:0] waits;
        logic             err;
    } plan_t;

    // Map a wait code to a wait count: linear up to 3, then 4, 6, 8, 10.
    function automatic logic [CNT_W-1:0] wait_decode(input logic [CODE_W-1:0] code);
        logic [CNT_W-1:0] low;
        low = CNT_W'(code[CODE_W-2:0]);
        if (!code[CODE_W-1])
            return low;
        return CNT_W'((low << 1) + CNT_W'(4));
    endfunction
endpackage

// File: rtl/ewc_cfg_sel.sv
`timescale 1ns/1ps
// Region configuration selector.
// Picks the configuration group for the requested region, applies the
// memory-card width override, decodes the wait code and flags an illegal
// CP wait code. Purely combinational; assumes inputs are stable in the
// cycle the request is taken.
module ewc_cfg_sel
    import ewc_pkg::*;
#(
    parameter int BASIC_CODE_W = 2
) (
    input  logic [1:0]              region,
    input  logic                    basic_wide,
    input  logic                    basic_3st,
    input  logic [BASIC_CODE_W-1:0] basic_code,
    input  logic                    cpcf_en,
    input  logic                    cpcf_wide,
    input  logic                    cpcf_3st,
    input  logic [CODE_W-1:0]       cpcf_code,
    input  logic                    card_mode,
    output plan_t                   plan
);
    logic cpcf_apply;

    // Waits on CP/CF need both the enable and the 3-state bit.
    assign cpcf_apply = cpcf_en & cpcf_3st;

    // Build the access plan for the selected region.
    always_comb begin
        plan = '0;
        unique case (region_e'(region))
            RGN_CP: begin
                plan.wide  = cpcf_wide | card_mode;
                plan.three = cpcf_3st;
                plan.err   = cpcf_apply & cpcf_code[CODE_W-1];
                plan.waits = cpcf_apply ?
                             wait_decode({1'b0, cpcf_code[CODE_W-2:0]}) : '0;
            end
            RGN_CF: begin
                plan.wide  = cpcf_wide;
                plan.three = cpcf_3st;
                plan.err   = 1'b0;
                plan.waits = cpcf_apply ? wait_decode(cpcf_code) : '0;
            end
            default: begin
                plan.wide  = basic_wide;
                plan.three = basic_3st;
                plan.err   = 1'b0;
                plan.waits = basic_3st ? CNT_W'(basic_code) : '0;
            end
        endcase
    end
endmodule

// File: rtl/ewc_seq.sv
`timescale 1ns/1ps
// Bus-state sequencer.
// Runs T1, T2, optional wait states and T3 for each byte cycle, or T1 and
// T2 only in 2-state mode, and repeats the sequence once when a 16-bit
// access must be split on an 8-bit bus. Captures the timing plan when a
// request is taken in the idle state; requests in other states are ignored.
module ewc_seq
    import ewc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  req_valid,
    input  logic  req_size16,
    input  plan_t plan_in,
    output logic  take,
    output logic  busy,
    output logic  first_state,
    output logic  second,
    output logic  byte_end,
    output logic  ready,
    output logic  wide_q,
    output logic  err_q
);
    bus_st_e          state;
    plan_t            plan_q;
    logic             split_q;
    logic [CNT_W-1:0] cnt;
    logic             last_byte;
    bus_st_e          after_byte;

    // Decode the current position in the access.
    always_comb begin
        take        = (state == ST_IDLE) & req_valid;
        busy        = (state != ST_IDLE);
        first_state = (state == ST_T1);
        byte_end    = ((state == ST_T2) & ~plan_q.three) | (state == ST_T3);
        last_byte   = ~split_q | second;
        ready       = byte_end & last_byte;
        after_byte  = last_byte ? ST_IDLE : ST_T1;
        wide_q      = plan_q.wide;
        err_q       = plan_q.err;
    end

    // Advance the bus state, wait counter and byte-cycle flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            plan_q  <= '0;
            split_q <= 1'b0;
            cnt     <= '0;
            second  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_T1;
                        plan_q  <= plan_in;
                        split_q <= req_size16 & ~plan_in.wide;
                        second  <= 1'b0;
                    end
                end
                ST_T1: state <= ST_T2;
                ST_T2: begin
                    if (!plan_q.three) begin
                        state <= after_byte;
                    end else if (plan_q.waits != '0) begin
                        state <= ST_TW;
                        cnt   <= CNT_W'(plan_q.waits - 1'b1);
                    end else begin
                        state <= ST_T3;
                    end
                end
                ST_TW: begin
                    if (cnt == '0)
                        state <= ST_T3;
                    else
                        cnt <= CNT_W'(cnt - 1'b1);
                end
                ST_T3: state <= after_byte;
                default: state <= ST_IDLE;
            endcase
            if (byte_end && !last_byte)
                second <= 1'b1;
        end
    end
endmodule

// File: rtl/ewc_lane.sv
`timescale 1ns/1ps
// Address, strobe and data-lane steering.
// Holds the request attributes for the running access, forms the byte or
// word address, steers write data onto the bus lanes, drives the strobes
// and assembles read data. Assumes an 8-bit bus uses lane [7:0].
module ewc_lane
    import ewc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic              req_size16,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic              busy,
    input  logic              first_state,
    input  logic              second,
    input  logic              byte_end,
    input  logic              ready,
    input  logic              wide,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_data_oe,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  req_rdata
);
    logic [AW-1:0]     addr_q;
    logic              write_q;
    logic              size_q;
    logic [BUS_W-1:0]  wdata_q;
    logic [LANE_W-1:0] hi_q;
    logic [AW-1:0]     cur_addr;
    logic [BUS_W-1:0]  lane_w;
    logic [BUS_W-1:0]  lane_r;

    // Capture the request attributes when the access starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            write_q <= 1'b0;
            size_q  <= 1'b0;
            wdata_q <= '0;
        end else if (take) begin
            addr_q  <= req_addr;
            write_q <= req_write;
            size_q  <= req_size16;
            wdata_q <= req_wdata;
        end
    end

    // Hold the upper byte read in the first half of a split access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_q <= '0;
        else if (byte_end && !ready)
            hi_q <= bus_rdata[LANE_W-1:0];
    end

    // Form the address of the current byte cycle.
    always_comb begin
        if (size_q)
            cur_addr = {addr_q[AW-1:1], ~wide & second};
        else
            cur_addr = addr_q;
    end

    // Steer write data onto the bus lanes.
    always_comb begin
        if (wide) begin
            if (size_q)
                lane_w = wdata_q;
            else if (addr_q[0])
                lane_w = {{LANE_W{1'b0}}, wdata_q[LANE_W-1:0]};
            else
                lane_w = {wdata_q[LANE_W-1:0], {LANE_W{1'b0}}};
        end else begin
            if (size_q && !second)
                lane_w = {{LANE_W{1'b0}}, wdata_q[BUS_W-1:LANE_W]};
            else
                lane_w = {{LANE_W{1'b0}}, wdata_q[LANE_W-1:0]};
        end
    end

    // Assemble read data from the bus lanes.
    always_comb begin
        if (wide) begin
            if (size_q)
                lane_r = bus_rdata;
            else if (addr_q[0])
                lane_r = {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
            else
                lane_r = {{LANE_W{1'b0}}, bus_rdata[BUS_W-1:LANE_W]};
        end else begin
            if (size_q)
                lane_r = {hi_q, bus_rdata[LANE_W-1:0]};
            else
                lane_r = {{LANE_W{1'b0}}, bus_rdata[LANE_W-1:0]};
        end
    end

    // Drive the bus and requester outputs, quiet when idle.
    always_comb begin
        bus_addr    = busy ? cur_addr : '0;
        bus_rd_n    = ~(busy & ~write_q);
        bus_wr_n    = ~(busy & write_q & ~first_state);
        bus_data_oe = busy & write_q;
        bus_wdata   = (busy & write_q) ? lane_w : '0;
        req_rdata   = (ready & ~write_q) ? lane_r : '0;
    end
endmodule

// File: rtl/ext_wait_ctrl.sv
`timescale 1ns/1ps
// External bus wait-state controller, top level.
// Selects the region timing, sequences the bus states and steers the data
// lanes. One access at a time; the requester waits for req_ready before
// issuing the next request.
module ext_wait_ctrl
    import ewc_pkg::*;
#(
    parameter int AW           = 16,
    parameter int BASIC_CODE_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [AW-1:0]           req_addr,
    input  logic                    req_write,
    input  logic                    req_size16,
    input  logic [1:0]              req_region,
    input  logic [BUS_W-1:0]        req_wdata,
    output logic                    req_ready,
    output logic [BUS_W-1:0]        req_rdata,
    input  logic                    cfg_basic_wide,
    input  logic                    cfg_basic_3st,
    input  logic [BASIC_CODE_W-1:0] cfg_basic_code,
    input  logic                    cfg_cpcf_en,
    input  logic                    cfg_cpcf_wide,
    input  logic                    cfg_cpcf_3st,
    input  logic [CODE_W-1:0]       cfg_cpcf_code,
    input  logic                    cfg_card_mode,
    output logic                    cfg_err,
    output logic [AW-1:0]           bus_addr,
    output logic                    bus_as_n,
    output logic                    bus_rd_n,
    output logic                    bus_wr_n,
    output logic                    bus_data_oe,
    output logic [BUS_W-1:0]        bus_wdata,
    input  logic [BUS_W-1:0]        bus_rdata
);
    plan_t plan_in;
    logic  take;
    logic  busy;
    logic  first_state;
    logic  second;
    logic  byte_end;
    logic  ready;
    logic  wide_q;
    logic  err_q;

    ewc_cfg_sel #(.BASIC_CODE_W(BASIC_CODE_W)) u_cfg_sel (
        .region     (req_region),
        .basic_wide (cfg_basic_wide),
        .basic_3st  (cfg_basic_3st),
        .basic_code (cfg_basic_code),
        .cpcf_en    (cfg_cpcf_en),
        .cpcf_wide  (cfg_cpcf_wide),
        .cpcf_3st   (cfg_cpcf_3st),
        .cpcf_code  (cfg_cpcf_code),
        .card_mode  (cfg_card_mode),
        .plan       (plan_in)
    );

    ewc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_size16  (req_size16),
        .plan_in     (plan_in),
        .take        (take),
        .busy        (busy),
        .first_state (first_state),
        .second      (second),
        .byte_end    (byte_end),
        .ready       (ready),
        .wide_q      (wide_q),
        .err_q       (err_q)
    );

    ewc_lane #(.AW(AW)) u_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (take),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_size16  (req_size16),
        .req_wdata   (req_wdata),
        .busy        (busy),
        .first_state (first_state),
        .second      (second),
        .byte_end    (byte_end),
        .ready       (ready),
        .wide        (wide_q),
        .bus_rdata   (bus_rdata),
        .bus_addr    (bus_addr),
        .bus_rd_n    (bus_rd_n),
        .bus_wr_n    (bus_wr_n),
        .bus_data_oe (bus_data_oe),
        .bus_wdata   (bus_wdata),
        .req_rdata   (req_rdata)
    );

    // Requester-facing status drawn from the sequencer.
    always_comb begin
        bus_as_n  = ~busy;
        req_ready = ready;
        cfg_err   = busy & err_q;
    end
endmodule

// File: rtl/ewc_checker.sv
`timescale 1ns/1ps
// Protocol checker for the external bus wait-state controller, bound to
// the top module. Observes ports only.
module ewc_checker (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic cfg_err,
    input logic bus_as_n,
    input logic bus_rd_n,
    input logic bus_wr_n,
    input logic bus_data_oe
);
    // R1: an idle request starts an access in the next cycle.
    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_as_n && req_valid) |=> !bus_as_n);

    // R11: completion only inside an access, and only for one cycle.
    p_ready_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !bus_as_n);
    p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R10: read and write strobes never overlap; write strobe implies drive.
    p_no_rdwr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));
    p_wr_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> bus_data_oe);
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n) && !$past(req_ready)) |-> $stable(bus_rd_n));

    // R6: the error flag lives only inside an access and holds through it.
    p_err_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !bus_as_n);
    p_err_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_as_n && $past(!bus_as_n) && !$past(req_ready)) |-> $stable(cfg_err));
endmodule

bind ext_wait_ctrl ewc_checker u_ewc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .cfg_err     (cfg_err),
    .bus_as_n    (bus_as_n),
    .bus_rd_n    (bus_rd_n),
    .bus_wr_n    (bus_wr_n),
    .bus_data_oe (bus_data_oe)
);

// File: tb/test_ext_wait_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle prediction of all outputs, compared on
// every falling clock edge.
module test_ext_wait_ctrl;
    localparam int AW = 16;

    typedef struct packed {
        logic        as_n;
        logic        rd_n;
        logic        wr_n;
        logic        oe;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic        ready;
        logic [15:0] rdata;
        logic        err;
    } exp_t;

    localparam exp_t IDLE_E = '{as_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, oe: 1'b0,
                                addr: 16'h0, wdata: 16'h0, ready: 1'b0,
                                rdata: 16'h0, err: 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_size16 = 1'b0;
    logic [1:0]  req_region = '0;
    logic [15:0] req_wdata = '0;
    logic        b_wide = 1'b1, b_3st = 1'b0;
    logic [1:0]  b_code = '0;
    logic        c_en = 1'b0, c_wide = 1'b1, c_3st = 1'b0, c_card = 1'b0;
    logic [2:0]  c_code = 3'b111;
    logic        req_ready, cfg_err, bus_as_n, bus_rd_n, bus_wr_n, bus_data_oe;
    logic [15:0] req_rdata, bus_addr, bus_wdata, bus_rdata;

    int   vectors = 0;
    int   miscompares = 0;
    bit   armed = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    function automatic logic [15:0] mem_rd(input logic [15:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8] ^ a[7:0] ^ 8'h3C};
    endfunction

    assign bus_rdata = mem_rd(bus_addr);

    ext_wait_ctrl #(.AW(AW), .BASIC_CODE_W(2)) i_ext_wait_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_size16(req_size16), .req_region(req_region), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata),
        .cfg_basic_wide(b_wide), .cfg_basic_3st(b_3st), .cfg_basic_code(b_code),
        .cfg_cpcf_en(c_en), .cfg_cpcf_wide(c_wide), .cfg_cpcf_3st(c_3st),
        .cfg_cpcf_code(c_code), .cfg_card_mode(c_card), .cfg_err(cfg_err),
        .bus_addr(bus_addr), .bus_as_n(bus_as_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_data_oe(bus_data_oe), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Per-cycle comparison against the predicted timeline.
    always @(negedge clk) begin
        exp_t e;
        bit   bad;
        if (armed) begin
            e = (q.size() > 0) ? q.pop_front() : IDLE_E;
            vectors++;
            bad = 1'b0;
            if (bus_as_n !== e.as_n) begin
                $display("FAIL R3 bus_as_n actual %b expected %b at %0t", bus_as_n, e.as_n, $time); bad = 1'b1; end
            if (bus_rd_n !== e.rd_n) begin
                $display("FAIL R10 bus_rd_n actual %b expected %b at %0t", bus_rd_n, e.rd_n, $time); bad = 1'b1; end
            if (bus_wr_n !== e.wr_n) begin
                $display("FAIL R10 bus_wr_n actual %b expected %b at %0t", bus_wr_n, e.wr_n, $time); bad = 1'b1; end
            if (bus_data_oe !== e.oe) begin
                $display("FAIL R10 bus_data_oe actual %b expected %b at %0t", bus_data_oe, e.oe, $time); bad = 1'b1; end
            if (bus_addr !== e.addr) begin
                $display("FAIL R8 bus_addr actual %h expected %h at %0t", bus_addr, e.addr, $time); bad = 1'b1; end
            if (bus_wdata !== e.wdata) begin
                $display("FAIL R9 bus_wdata actual %h expected %h at %0t", bus_wdata, e.wdata, $time); bad = 1'b1; end
            if (req_ready !== e.ready) begin
                $display("FAIL R11 req_ready actual %b expected %b at %0t", req_ready, e.ready, $time); bad = 1'b1; end
            if (req_rdata !== e.rdata) begin
                $display("FAIL R11 req_rdata actual %h expected %h at %0t", req_rdata, e.rdata, $time); bad = 1'b1; end
            if (cfg_err !== e.err) begin
                $display("FAIL R6 cfg_err actual %b expected %b at %0t", cfg_err, e.err, $time); bad = 1'b1; end
            if (bad) miscompares++;
        end
    end

    // Timing plan of a region from the requirements (R2 R4 R5 R6 R7).
    task automatic plan_of(input logic [1:0] rg, output logic wide, output logic three,
                           output int waits, output logic err);
        logic apply;
        apply = c_en & c_3st;
        err   = 1'b0;
        if (rg == 2'd1) begin
            wide  = c_wide | c_card;
            three = c_3st;
            err   = apply & c_code[2];
            waits = apply ? int'(c_code[1:0]) : 0;
        end else if (rg == 2'd2) begin
            wide  = c_wide;
            three = c_3st;
            case (c_code)
                3'd0: waits = 0;  3'd1: waits = 1;  3'd2: waits = 2;  3'd3: waits = 3;
                3'd4: waits = 4;  3'd5: waits = 6;  3'd6: waits = 8;  default: waits = 10;
            endcase
            if (!apply) waits = 0;
        end else begin
            wide  = b_wide;
            three = b_3st;
            waits = b_3st ? int'(b_code) : 0;
        end
    endtask

    // Issue one access and queue its predicted timeline.
    task automatic do_access(input logic [1:0] rg, input logic [15:0] a,
                             input logic wr, input logic s16, input logic [15:0] wd);
        logic        wide, three, err, split;
        int          waits, nbytes, n;
        logic [15:0] ba, bw, rx;
        exp_t        e;
        while (q.size() != 0) @(negedge clk);
        plan_of(rg, wide, three, waits, err);
        @(posedge clk); #1;
        req_valid = 1'b1; req_region = rg; req_addr = a;
        req_write = wr; req_size16 = s16; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        split  = s16 & ~wide;
        nbytes = split ? 2 : 1;
        n      = three ? 3 + waits : 2;
        if (split)
            rx = {mem_rd({a[15:1], 1'b0})[7:0], mem_rd({a[15:1], 1'b1})[7:0]};
        else if (!wide)
            rx = {8'h00, mem_rd(a)[7:0]};
        else if (s16)
            rx = mem_rd({a[15:1], 1'b0});
        else
            rx = a[0] ? {8'h00, mem_rd(a)[7:0]} : {8'h00, mem_rd(a)[15:8]};
        for (int b = 0; b < nbytes; b++) begin
            if (split) begin
                ba = {a[15:1], b[0]};
                bw = (b == 0) ? {8'h00, wd[15:8]} : {8'h00, wd[7:0]};
            end else if (!wide) begin
                ba = a;
                bw = {8'h00, wd[7:0]};
            end else if (s16) begin
                ba = {a[15:1], 1'b0};
                bw = wd;
            end else begin
                ba = a;
                bw = a[0] ? {8'h00, wd[7:0]} : {wd[7:0], 8'h00};
            end
            for (int i = 0; i < n; i++) begin
                e.as_n  = 1'b0;
                e.rd_n  = wr;
                e.wr_n  = ~(wr & (i != 0));
                e.oe    = wr;
                e.addr  = ba;
                e.wdata = wr ? bw : 16'h0;
                e.ready = (b == nbytes - 1) && (i == n - 1);
                e.rdata = (e.ready && !wr) ? rx : 16'h0;
                e.err   = err;
                q.push_back(e);
            end
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (2) @(posedge clk);
        armed = 1'b1;                                  // R13: idle outputs in reset
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);                     // R13: idle after reset

        // R2: basic 2-state ignores its wait code
        b_wide = 1'b1; b_3st = 1'b0; b_code = 2'd3;
        do_access(2'd0, 16'h1234, 1'b1, 1'b0, 16'h00C7);
        do_access(2'd0, 16'h1235, 1'b0, 1'b0, 16'h0);
        // R3: basic 3-state with 2 waits, word read and write
        b_3st = 1'b1; b_code = 2'd2;
        do_access(2'd0, 16'h2040, 1'b0, 1'b1, 16'h0);
        do_access(2'd0, 16'h2042, 1'b1, 1'b1, 16'hBEEF);
        b_code = 2'd0;
        do_access(2'd0, 16'h2044, 1'b0, 1'b1, 16'h0);
        // R4: every CF wait code, narrow byte reads
        c_en = 1'b1; c_3st = 1'b1; c_wide = 1'b0;
        for (int c = 0; c < 8; c++) begin
            c_code = 3'(c);
            do_access(2'd2, 16'h8000 + 16'(c), 1'b0, 1'b0, 16'h0);
        end
        // R5: enable off keeps 3 states without waits
        c_en = 1'b0; c_code = 3'd7;
        do_access(2'd2, 16'h8100, 1'b1, 1'b0, 16'h005A);
        // R5 with R2: enable on, 2-state
        c_en = 1'b1; c_3st = 1'b0;
        do_access(2'd2, 16'h8102, 1'b0, 1'b0, 16'h0);
        // R6: illegal CP code raises the error, waits from low bits
        c_3st = 1'b1; c_code = 3'd5;
        do_access(2'd1, 16'h4010, 1'b0, 1'b0, 16'h0);
        c_code = 3'd3;
        do_access(2'd1, 16'h4011, 1'b1, 1'b0, 16'h0033);
        // R7: card mode widens CP only; CF stays narrow and splits (R8)
        c_card = 1'b1; c_wide = 1'b0; c_code = 3'd1;
        do_access(2'd1, 16'h4020, 1'b0, 1'b1, 16'h0);
        do_access(2'd2, 16'h8020, 1'b0, 1'b1, 16'h0);
        c_card = 1'b0;
        do_access(2'd1, 16'h4022, 1'b1, 1'b1, 16'hA1B2);
        // R8: split write and read from an odd request address
        do_access(2'd2, 16'h8031, 1'b1, 1'b1, 16'h1357);
        do_access(2'd2, 16'h8033, 1'b0, 1'b1, 16'h0);
        // R9: lanes on a 16-bit bus, even and odd bytes
        b_wide = 1'b1; b_3st = 1'b0;
        do_access(2'd0, 16'h3000, 1'b1, 1'b0, 16'h0066);
        do_access(2'd0, 16'h3001, 1'b1, 1'b0, 16'h0077);
        do_access(2'd0, 16'h3002, 1'b0, 1'b0, 16'h0);
        do_access(2'd3, 16'h3003, 1'b0, 1'b0, 16'h0);
        // R12: configuration changed while a split access runs
        c_en = 1'b1; c_3st = 1'b1; c_wide = 1'b0; c_code = 3'd6;
        do_access(2'd2, 16'h8040, 1'b1, 1'b1, 16'hC3D4);
        c_code = 3'd0; c_wide = 1'b1; c_3st = 1'b0; c_en = 1'b0;
        // R1: a request during a running access is ignored
        c_en = 1'b1; c_3st = 1'b1; c_wide = 1'b0; c_code = 3'd7;
        do_access(2'd2, 16'h8050, 1'b0, 1'b0, 16'h0);
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = 16'h7777; req_write = 1'b1; req_wdata = 16'hFFFF;
        @(posedge clk); #1;
        req_valid = 1'b0;
        while (q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL R1 watchdog: actual still running, expected all accesses done");
        finish_run();
    end
endmodule